// File: doc/BRIEF.md
# Lockable Configuration Control Register Bank

This block holds a small bank of device configuration registers behind a 32-bit word port with per-byte enables. It contains a 16-bit control field, a 4-bit sticky status field, a seal (lock) register and, for each of `NUM_RANGES` memory windows, a 64-bit base address split into a low and a high word. Each register byte has a fixed write mask. Bits outside the mask keep their stored value when a write arrives.

Sealing works as a two-state machine. The states are `LK_OPEN` and `LK_SEALED`. The transition `SEAL` goes from `LK_OPEN` to `LK_SEALED` when a 1 is written to seal bit 0. The transition `UNSEAL` goes from `LK_SEALED` back to `LK_OPEN` only on a warm or cold reset. While the block is sealed, the control field and every range base are read-only, and the seal register cannot be changed.

The status bits are set by pulses from device logic and are cleared by software writing 1s to them. A warm reset leaves the status bits unchanged. Only a cold reset clears them.

Top module: `cfglk_regs`

Word map (word index = `wr_addr`/`rd_addr`):
- Word 0: control in bits 15:0, status in bits 19:16.
- Word 1: seal bit in bit 0.
- Word 2+2k: low word of range k.
- Word 3+2k: high word of range k.
- Any other word reads as 0.

## Requirements
- R1: Control bits 7:0 take write mask 0xFD and bits 15:8 take mask 0x4F. Each byte is written only when its byte enable is set.
- R2: Writing word 1 with byte enable 0 and data bit 0 = 1 moves `LK_OPEN` to `LK_SEALED`. Word 1 bit 0 and `locked_o` then read 1. Any later write to word 1 has no effect until a reset.
- R3: While sealed, writes to word 0 bits 15:0 and to every range word leave them unchanged.
- R4: Writing a 1 to status bit n (word 0 bit 16+n, byte enable 2) clears that bit. Writing a 0 leaves it as it is. Sealing does not block these clears.
- R5: A pulse on `sts_set[n]` sets status bit n on the next cycle. If a set and a clear of the same bit arrive in the same cycle, the set wins.
- R6: Each range high word is writable in all 32 bits.
- R7: Each range low word stores only bits 31:28. Bits 27:0 always read 0.
- R8: `cold_rst` clears every register, including status, and leaves the block in `LK_OPEN`.
- R9: `warm_rst` clears the control field, the seal and all range words, and leaves the status bits unchanged.
- R10: `rd_data` returns the stored word for `rd_addr` in the same cycle, and unmapped words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst | input | 1 | Synchronous full reset, including status |
| warm_rst | input | 1 | Synchronous reset that keeps status |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Word index of the write |
| wr_be | input | 4 | Per-byte write enables |
| wr_data | input | 32 | Write data |
| sts_set | input | 4 | Status set pulses from device logic |
| rd_addr | input | AW | Word index of the read |
| rd_data | output | 32 | Read data (combinational) |
| ctrl_o | output | 16 | Current control field |
| status_o | output | 4 | Current sticky status |
| locked_o | output | 1 | High while sealed |
| range_base_o | output | 64*NUM_RANGES | Range bases, range k in bits 64k+63:64k |

## Verification
The assertions assume that the two resets are applied as synchronous pulses. The bench holds `sts_set` and `wr_en` low during any reset cycle. The checks on held values are disabled during resets, because a reset may legitimately change those values. The random stimulus draws addresses from the whole word space, including unmapped words, and draws arbitrary byte enables and data. Warm resets are sprinkled in so the seal opens again and the register bank can be rewritten after it has been sealed.

// File: rtl/cfglk_pkg.sv
package cfglk_pkg;
    localparam logic [15:0] CTRL_MASK   = 16'h4FFD;
    localparam logic [31:0] RLO_MASK    = 32'hF000_0000;
    localparam logic [31:0] RHI_MASK    = 32'hFFFF_FFFF;
    localparam int          W_CTRL      = 0;
    localparam int          W_SEAL      = 1;
    localparam int          W_RANGE0    = 2;

    typedef enum logic {
        LK_OPEN   = 1'b0,
        LK_SEALED = 1'b1
    } lk_state_e;
endpackage

// File: rtl/cfglk_seal_fsm.sv
module cfglk_seal_fsm
    import cfglk_pkg::*;
(
    input  logic clk,
    input  logic rst_any,
    input  logic seal_req,
    output logic sealed
);
    lk_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_OPEN:   if (seal_req) state_d = LK_SEALED;
            LK_SEALED: state_d = LK_SEALED;
            default:   state_d = LK_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst_any) state_q <= LK_OPEN;
        else         state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            LK_SEALED: sealed = 1'b1;
            default:   sealed = 1'b0;
        endcase
    end
endmodule

// File: rtl/cfglk_mreg.sv
module cfglk_mreg #(
    parameter int NBYTES = 4,
    parameter logic [8*NBYTES-1:0] MASK = '1
) (
    input  logic                  clk,
    input  logic                  clr,
    input  logic                  wr,
    input  logic [NBYTES-1:0]     be,
    input  logic [8*NBYTES-1:0]   d,
    output logic [8*NBYTES-1:0]   q
);
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        localparam logic [7:0] BM = MASK[8*b +: 8];
        if (BM == 8'h00) begin : g_ro
            assign q[8*b +: 8] = 8'h00;
        end else begin : g_rw
            logic [7:0] byte_q;
            always_ff @(posedge clk) begin
                if (clr)
                    byte_q <= 8'h00;
                else if (wr && be[b])
                    byte_q <= (byte_q & ~BM) | (d[8*b +: 8] & BM);
            end
            assign q[8*b +: 8] = byte_q;
        end
    end
endmodule

// File: rtl/cfglk_sticky.sv
module cfglk_sticky #(
    parameter int NBITS = 4
) (
    input  logic             clk,
    input  logic             cold_rst,
    input  logic             clr_wr,
    input  logic [NBITS-1:0] clr_bits,
    input  logic [NBITS-1:0] set_bits,
    output logic [NBITS-1:0] q
);
    logic [NBITS-1:0] kill;
    assign kill = clr_wr ? clr_bits : '0;

    always_ff @(posedge clk) begin
        if (cold_rst) q <= '0;
        else          q <= (q & ~kill) | set_bits;
    end
endmodule

// File: rtl/cfglk_regs.sv
module cfglk_regs
    import cfglk_pkg::*;
#(
    parameter int NUM_RANGES = 2,
    parameter int STS_BITS   = 4,
    localparam int NWORDS    = W_RANGE0 + 2 * NUM_RANGES,
    localparam int AW        = $clog2(NWORDS + 1)
) (
    input  logic                     clk,
    input  logic                     cold_rst,
    input  logic                     warm_rst,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_addr,
    input  logic [3:0]               wr_be,
    input  logic [31:0]              wr_data,
    input  logic [STS_BITS-1:0]      sts_set,
    input  logic [AW-1:0]            rd_addr,
    output logic [31:0]              rd_data,
    output logic [15:0]              ctrl_o,
    output logic [STS_BITS-1:0]      status_o,
    output logic                     locked_o,
    output logic [64*NUM_RANGES-1:0] range_base_o
);
    logic rst_any;
    logic hit_ctrl, hit_seal;
    assign rst_any  = cold_rst | warm_rst;
    assign hit_ctrl = wr_en && (wr_addr == AW'(W_CTRL));
    assign hit_seal = wr_en && (wr_addr == AW'(W_SEAL));

    cfglk_seal_fsm u_seal (
        .clk      (clk),
        .rst_any  (rst_any),
        .seal_req (hit_seal && wr_be[0] && wr_data[0]),
        .sealed   (locked_o)
    );

    cfglk_mreg #(.NBYTES(2), .MASK(CTRL_MASK)) u_ctrl (
        .clk (clk),
        .clr (rst_any),
        .wr  (hit_ctrl && !locked_o),
        .be  (wr_be[1:0]),
        .d   (wr_data[15:0]),
        .q   (ctrl_o)
    );

    cfglk_sticky #(.NBITS(STS_BITS)) u_sts (
        .clk      (clk),
        .cold_rst (cold_rst),
        .clr_wr   (hit_ctrl && wr_be[2]),
        .clr_bits (wr_data[16 +: STS_BITS]),
        .set_bits (sts_set),
        .q        (status_o)
    );

    logic [31:0] rlo [NUM_RANGES];
    logic [31:0] rhi [NUM_RANGES];

    for (genvar k = 0; k < NUM_RANGES; k++) begin : g_rng
        localparam int WLO = W_RANGE0 + 2 * k;
        cfglk_mreg #(.NBYTES(4), .MASK(RLO_MASK)) u_lo (
            .clk (clk),
            .clr (rst_any),
            .wr  (wr_en && !locked_o && (wr_addr == AW'(WLO))),
            .be  (wr_be),
            .d   (wr_data),
            .q   (rlo[k])
        );
        cfglk_mreg #(.NBYTES(4), .MASK(RHI_MASK)) u_hi (
            .clk (clk),
            .clr (rst_any),
            .wr  (wr_en && !locked_o && (wr_addr == AW'(WLO + 1))),
            .be  (wr_be),
            .d   (wr_data),
            .q   (rhi[k])
        );
        assign range_base_o[64*k +: 64] = {rhi[k], rlo[k]};
    end

    always_comb begin
        rd_data = 32'h0;
        if (rd_addr == AW'(W_CTRL))
            rd_data = {{(16 - STS_BITS){1'b0}}, status_o, ctrl_o};
        else if (rd_addr == AW'(W_SEAL))
            rd_data = {31'h0, locked_o};
        for (int k = 0; k < NUM_RANGES; k++) begin
            if (rd_addr == AW'(W_RANGE0 + 2 * k))     rd_data = rlo[k];
            if (rd_addr == AW'(W_RANGE0 + 2 * k + 1)) rd_data = rhi[k];
        end
    end
endmodule

// File: rtl/cfglk_chk.sv
module cfglk_chk #(
    parameter int NUM_RANGES = 2,
    parameter int STS_BITS   = 4,
    parameter int AW         = 3
) (
    input logic                     clk,
    input logic                     cold_rst,
    input logic                     warm_rst,
    input logic                     wr_en,
    input logic [AW-1:0]            wr_addr,
    input logic [STS_BITS-1:0]      sts_set,
    input logic [15:0]              ctrl_o,
    input logic [STS_BITS-1:0]      status_o,
    input logic                     locked_o,
    input logic [64*NUM_RANGES-1:0] range_base_o
);
    // R2
    seal_hold_chk: assert property (@(posedge clk) disable iff (cold_rst || warm_rst)
        locked_o |=> locked_o);

    // R3
    ctrl_frozen_chk: assert property (@(posedge clk) disable iff (cold_rst || warm_rst)
        (locked_o && wr_en && wr_addr == '0) |=> $stable(ctrl_o));

    // R3
    range_frozen_chk: assert property (@(posedge clk) disable iff (cold_rst || warm_rst)
        locked_o |=> $stable(range_base_o));

    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (cold_rst)
        (|sts_set) |=> ((status_o & $past(sts_set)) == $past(sts_set)));

    // R9
    warm_keeps_sts_chk: assert property (@(posedge clk) disable iff (cold_rst)
        (warm_rst && !wr_en) |=> ((status_o & $past(status_o)) == $past(status_o)));

    // R9
    warm_unseals_chk: assert property (@(posedge clk) disable iff (cold_rst)
        warm_rst |=> (!locked_o && ctrl_o == 16'h0));
endmodule

bind cfglk_regs cfglk_chk #(.NUM_RANGES(NUM_RANGES), .STS_BITS(STS_BITS), .AW(AW)) u_chk (
    .clk          (clk),
    .cold_rst     (cold_rst),
    .warm_rst     (warm_rst),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .sts_set      (sts_set),
    .ctrl_o       (ctrl_o),
    .status_o     (status_o),
    .locked_o     (locked_o),
    .range_base_o (range_base_o)
);

// File: tb/cfglk_regs_tb.sv
module cfglk_regs_tb_top;
    localparam int NR = 2;
    localparam int AW = 3;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          cold_rst, warm_rst, wr_en;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [3:0]    wr_be, sts_set;
    logic [31:0]   wr_data, rd_data;
    logic [15:0]   ctrl_o;
    logic [3:0]    status_o;
    logic          locked_o;
    logic [64*NR-1:0] range_base_o;

    cfglk_regs #(.NUM_RANGES(NR)) dut_i (
        .clk(clk), .cold_rst(cold_rst), .warm_rst(warm_rst), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_be(wr_be), .wr_data(wr_data), .sts_set(sts_set),
        .rd_addr(rd_addr), .rd_data(rd_data), .ctrl_o(ctrl_o),
        .status_o(status_o), .locked_o(locked_o), .range_base_o(range_base_o)
    );

    int checks = 0;
    int errors = 0;

    logic [15:0] m_ctrl;
    logic [3:0]  m_sts;
    logic        m_lock;
    logic [31:0] m_rlo [NR];
    logic [31:0] m_rhi [NR];

    function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] d,
                                          logic [3:0] be, logic [31:0] m);
        logic [31:0] bm;
        for (int b = 0; b < 4; b++) bm[8*b +: 8] = be[b] ? m[8*b +: 8] : 8'h0;
        return (o & ~bm) | (d & bm);
    endfunction

    function automatic logic [31:0] exp_word(int a);
        if (a == 0) return {12'h0, m_sts, m_ctrl};
        if (a == 1) return {31'h0, m_lock};
        if (a >= 2 && a < 2 + 2 * NR)
            return (a % 2 == 0) ? m_rlo[(a - 2) / 2] : m_rhi[(a - 2) / 2];
        return 32'h0;
    endfunction

    function automatic string req_of(int a);
        if (a == 0) return "R1/R4/R5";
        if (a == 1) return "R2";
        if (a >= 2 && a < 2 + 2 * NR) return (a % 2 == 0) ? "R7/R3" : "R6/R3";
        return "R10";
    endfunction

    task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        for (int a = 0; a < 8; a++) begin
            rd_addr = AW'(a);
            #1;
            chk({tag, " ", req_of(a)}, rd_data, exp_word(a));
        end
    endtask

    task automatic model_reset(bit cold);
        m_ctrl = '0; m_lock = 1'b0;
        for (int k = 0; k < NR; k++) begin m_rlo[k] = '0; m_rhi[k] = '0; end
        if (cold) m_sts = '0;
    endtask

    task automatic do_reset(bit cold);
        @(negedge clk);
        cold_rst = cold; warm_rst = !cold; wr_en = 0; sts_set = 0;
        @(negedge clk);
        cold_rst = 0; warm_rst = 0;
        model_reset(cold);
    endtask

    task automatic op(bit we, int a, logic [3:0] be, logic [31:0] d, logic [3:0] st);
        logic [3:0] clr;
        @(negedge clk);
        wr_en = we; wr_addr = AW'(a); wr_be = be; wr_data = d; sts_set = st;
        clr = 4'h0;
        if (we) begin
            if (a == 0) begin
                if (!m_lock) m_ctrl = merge({16'h0, m_ctrl}, d, be, 32'h0000_4FFD)[15:0];
                if (be[2]) clr = d[19:16];
            end else if (a == 1) begin
                if (!m_lock && be[0] && d[0]) m_lock = 1'b1;
            end else if (a < 2 + 2 * NR && !m_lock) begin
                if (a % 2 == 0) m_rlo[(a - 2) / 2] = merge(m_rlo[(a - 2) / 2], d, be, 32'hF000_0000);
                else            m_rhi[(a - 2) / 2] = merge(m_rhi[(a - 2) / 2], d, be, 32'hFFFF_FFFF);
            end
        end
        m_sts = (m_sts & ~clr) | st;
        @(negedge clk);
        wr_en = 0; sts_set = 0;
    endtask

    initial begin
        cold_rst = 1; warm_rst = 0; wr_en = 0; wr_addr = 0; wr_be = 0;
        wr_data = 0; sts_set = 0; rd_addr = 0;
        void'($urandom(32'd1234));
        model_reset(1);
        repeat (2) @(negedge clk);
        cold_rst = 0;
        // R8: reset state
        check_all("R8 reset");
        chk("R8 locked_o", {31'h0, locked_o}, 32'h0);

        // R1: control masks
        op(1, 0, 4'h3, 32'hFFFF_FFFF, 0);
        check_all("R1 ctrl all-ones");
        chk("R1 ctrl_o", {16'h0, ctrl_o}, 32'h4FFD);
        op(1, 0, 4'h2, 32'h0000_0000, 0);
        check_all("R1 byte1 only");
        // R6 / R7
        op(1, 2, 4'hF, 32'hFFFF_FFFF, 0);
        op(1, 3, 4'hF, 32'hA5A5_5A5A, 0);
        check_all("R6 R7 range");
        // R5: set wins over clear same cycle
        op(0, 0, 0, 0, 4'h5);
        op(1, 0, 4'h4, 32'h000F_0000, 4'h1);
        check_all("R5 set wins R4 clear");
        chk("R5 status_o", {28'h0, status_o}, 32'h1);
        // R2 / R3: seal, then attempt writes
        op(1, 1, 4'h1, 32'h1, 0);
        chk("R2 locked_o", {31'h0, locked_o}, 32'h1);
        op(1, 1, 4'hF, 32'h0, 0);
        op(1, 0, 4'hF, 32'h0001_0000, 4'h2);
        op(1, 5, 4'hF, 32'hDEAD_BEEF, 0);
        check_all("R3 sealed");
        // R9: warm reset keeps status
        do_reset(0);
        check_all("R9 warm");
        chk("R9 status kept", {28'h0, status_o}, 32'h2);

        for (int i = 0; i < 400; i++) begin
            int a;
            a = int'($urandom_range(0, 7));
            if ($urandom_range(0, 39) == 0) do_reset(0);
            op(1'($urandom_range(0, 3) != 0), a, 4'($urandom),
               $urandom, ($urandom_range(0, 4) == 0) ? 4'($urandom) : 4'h0);
            check_all("R10 random");
        end

        op(0, 0, 0, 0, 4'hF);
        do_reset(1);
        check_all("R8 cold");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule